// File: doc/BRIEF.md
# Zero-Cross Digital Volume Control

This block scales a stereo stream of 24-bit two's complement PCM samples by a separate digital gain for each channel. Gain is set with an 8-bit code in half-decibel steps. The top code is unity. Each step down adds 0.5 dB of attenuation, and codes below a floor silence the channel. The product is rounded and clamped to 24 bits. It is registered once, so each scaled sample appears one cycle after its input strobe.

To keep gain changes free of clicks and zipper noise, a write can be held back until the audio passes through zero. This happens when the global zero-cross enable is high. The new code waits in a pending register for its channel. It is committed on the first sample of that channel whose sign differs from the channel's previous sample, or which is exactly zero. If no such sample arrives, a sample counter forces the update after a fixed number of samples. When the enable is low, writes take effect at once.

Top module: `zc_volume`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock cycle. `out_left`/`out_right` update only with a valid sample and hold their value otherwise.
- R2: For a code c at or above the mute floor, the output is computed as follows. Let K(c) = round(32768 · 10^(−(255−c)/40)). The output is then floor((x·K(c) + 16384) / 32768), clamped to the signed 24-bit range. Code 0xFF is unity gain.
- R3: Codes below 0x80 give an output of exactly zero. Code 0x80 is the lowest code that still passes signal.
- R4: `gain_sel` = 0 addresses the left channel and 1 addresses the right channel. A write to one channel never alters the other channel's output.
- R5: With `zc_en` low, a written code is used from the next valid sample onward, and any pending code for that channel is discarded.
- R6: With `zc_en` high, a written code is held pending. It is applied on the first later sample of that channel that is zero, or whose sign bit differs from the channel's previous valid sample. That sample is itself scaled with the new code.
- R7: A pending code is forced in on the 1024th valid sample after the write that opened the pending state, even without a crossing. Further writes while pending do not restart this count.
- R8: A write while a code is pending replaces it. Only the latest code is ever applied.
- R9: When a write and a valid sample reach the same channel in one cycle, the sample is scaled using the state before the write. If that sample commits an older pending code, the new write opens a fresh pending window.
- R10: A pending code that meets a valid sample while `zc_en` is low is applied on that sample.
- R11: After reset both channels are at code 0xFF, nothing is pending, the previous sign of both channels counts as non-negative, and the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zc_en | input | 1 | Defer gain writes to a zero crossing |
| gain_wr | input | 1 | Gain write strobe |
| gain_sel | input | 1 | Channel of the write (0 left, 1 right) |
| gain_code | input | 8 | Gain code, 0xFF = 0 dB, 0.5 dB per step |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 24 | Left input sample |
| in_right | input | 24 | Right input sample |
| out_valid | output | 1 | Scaled sample strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
The delicate overlap is a gain write and a sample that commits the channel's pending code, both landing in one cycle. That sample must use the older pending code, and the write must open a new window with a cleared timeout count. The bench provokes it by driving the strobe and a sign-changing sample together. It also provokes the same overlap with the enable low, and with the timeout's last sample. A behavioural model applies the sample first and the write second, and the outputs of every following cycle are compared with it.

// File: rtl/zc_volume.sv
module zc_volume #(
  parameter int DW         = 24,
  parameter int CW         = 16,
  parameter int GW         = 8,
  parameter int TIMEOUT    = 1024,
  parameter int MUTE_BELOW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zc_en,
  input  logic          gain_wr,
  input  logic          gain_sel,
  input  logic [GW-1:0] gain_code,
  input  logic          in_valid,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic          out_valid,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right
);
  localparam int NCH   = 2;
  localparam int NCODE = 1 << GW;
  localparam int FRAC  = CW - 1;
  localparam int CNTW  = $clog2(TIMEOUT);
  localparam int PW    = DW + CW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DW - 1));

  function automatic logic [CW-1:0] coef_of(int code);
    real steps;
    if (code < MUTE_BELOW) return '0;
    steps = real'(NCODE - 1 - code);
    return CW'($rtoi((2.0 ** FRAC) * (10.0 ** (-steps / 40.0)) + 0.5));
  endfunction

  logic [CW-1:0] rom [NCODE];
  for (genvar g = 0; g < NCODE; g++) begin : g_rom
    assign rom[g] = coef_of(g);
  end

  logic [NCH-1:0][DW-1:0]   smp;
  logic [NCH-1:0][DW-1:0]   out_q;
  logic [NCH-1:0][GW-1:0]   act_q;
  logic [NCH-1:0]           pend_q;
  logic [NCH-1:0][CNTW-1:0] cnt_q;

  assign smp       = {in_right, in_left};
  assign out_left  = out_q[0];
  assign out_right = out_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [GW-1:0]          act, pv;
    logic                   pend, neg;
    logic [CNTW-1:0]        cnt;
    logic [DW-1:0]          outr;
    logic                   is_zc, fire, wr_here;
    logic [GW-1:0]          use_code;
    logic signed [PW-1:0]   prod, rnd;
    logic signed [DW-1:0]   sat;

    assign wr_here  = gain_wr && (gain_sel == 1'(ch));
    assign is_zc    = (smp[ch][DW-1] != neg) || (smp[ch] == '0);
    assign fire     = pend && (is_zc || !zc_en || cnt == CNTW'(TIMEOUT - 1));
    assign use_code = fire ? pv : act;
    assign prod     = PW'($signed(smp[ch])) * PW'($signed({1'b0, rom[use_code]}));
    assign rnd      = (prod + HALF) >>> FRAC;

    always_comb begin
      if (rnd > MAXV)      sat = MAXV[DW-1:0];
      else if (rnd < MINV) sat = MINV[DW-1:0];
      else                 sat = rnd[DW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act  <= '1;
        pv   <= '1;
        pend <= 1'b0;
        neg  <= 1'b0;
        cnt  <= '0;
        outr <= '0;
      end else begin
        if (in_valid) begin
          neg  <= smp[ch][DW-1];
          outr <= sat;
          if (fire) begin
            act  <= pv;
            pend <= 1'b0;
            cnt  <= '0;
          end else if (pend) begin
            cnt <= cnt + 1'b1;
          end
        end
        if (wr_here) begin
          if (!zc_en) begin
            act  <= gain_code;
            pend <= 1'b0;
          end else begin
            pv   <= gain_code;
            pend <= 1'b1;
            if (!pend || (in_valid && fire)) cnt <= '0;
          end
        end
      end
    end

    assign out_q[ch]  = outr;
    assign act_q[ch]  = act;
    assign pend_q[ch] = pend;
    assign cnt_q[ch]  = cnt;
  end
endmodule

// File: rtl/zc_volume_chk.sv
module zc_volume_chk #(
  parameter int GW      = 8,
  parameter int CNTW    = 10,
  parameter int TIMEOUT = 1024
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 zc_en,
  input logic                 gain_wr,
  input logic                 gain_sel,
  input logic [GW-1:0]        gain_code,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [1:0][GW-1:0]   act,
  input logic [1:0]           pend,
  input logic [1:0][CNTW-1:0] cnt
);
  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    // R5
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_wr && !zc_en && gain_sel == 1'(ch)) |=> (act[ch] == $past(gain_code) && !pend[ch]));
    // R8
    hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_wr && zc_en && gain_sel == 1'(ch)) |=> pend[ch]);
    // R6
    act_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act[ch]) |-> ($past(in_valid) || $past(gain_wr && !zc_en && gain_sel == 1'(ch))));
    // R7
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[ch] && in_valid && cnt[ch] == CNTW'(TIMEOUT - 1) && !(gain_wr && gain_sel == 1'(ch)))
        |=> !pend[ch]);
  end
endmodule

bind zc_volume zc_volume_chk #(.GW(GW), .CNTW(CNTW), .TIMEOUT(TIMEOUT)) chk (
  .clk(clk), .rst_n(rst_n), .zc_en(zc_en), .gain_wr(gain_wr), .gain_sel(gain_sel),
  .gain_code(gain_code), .in_valid(in_valid), .out_valid(out_valid),
  .act(act_q), .pend(pend_q), .cnt(cnt_q)
);

// File: tb/zc_volume_test.sv
module zc_volume_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc_en = 1'b0, gain_wr = 1'b0, gain_sel = 1'b0, in_valid = 1'b0;
  logic [7:0]  gain_code = '0;
  logic [23:0] in_left = '0, in_right = '0;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  always #10 clk = ~clk;

  zc_volume uut (.*);

  int n_chk = 0, n_fail = 0;
  int act[2], pv[2], cnt[2];
  bit pend[2], neg[2];
  int exp_l = 0, exp_r = 0;
  bit exp_v = 0;
  bit zc = 0;

  function automatic int scale(int x, int code);
    longint k, p;
    if (code < 128) return 0;
    k = longint'($rtoi(32768.0 * (10.0 ** (-real'(255 - code) / 40.0)) + 0.5));
    p = (longint'(x) * k + 64'sd16384) >>> 15;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return int'(p);
  endfunction

  task automatic check(string tag);
    n_chk += 3;
    if (out_valid !== exp_v) begin
      n_fail++; $display("FAIL %s: out_valid=%0b expected %0b", tag, out_valid, exp_v);
    end
    if ($signed(out_left) !== exp_l) begin
      n_fail++; $display("FAIL %s: out_left=%0d expected %0d", tag, $signed(out_left), exp_l);
    end
    if ($signed(out_right) !== exp_r) begin
      n_fail++; $display("FAIL %s: out_right=%0d expected %0d", tag, $signed(out_right), exp_r);
    end
  endtask

  task automatic cyc(bit v, int l, int r, bit wr, bit sel, int code, string tag);
    in_valid = v; in_left = l[23:0]; in_right = r[23:0];
    gain_wr = wr; gain_sel = sel; gain_code = code[7:0]; zc_en = zc;
    if (v) begin
      for (int c = 0; c < 2; c++) begin
        int x, y, g;
        bit z, f;
        x = c ? r : l;
        z = ((x < 0) != neg[c]) || (x == 0);
        f = pend[c] && (z || !zc || cnt[c] == 1023);
        g = f ? pv[c] : act[c];
        y = scale(x, g);
        if (c == 0) exp_l = y; else exp_r = y;
        neg[c] = x < 0;
        if (f) begin act[c] = pv[c]; pend[c] = 0; cnt[c] = 0; end
        else if (pend[c]) cnt[c]++;
      end
    end
    exp_v = v;
    if (wr) begin
      int c = int'(sel);
      if (!zc) begin act[c] = code; pend[c] = 0; end
      else begin
        if (!pend[c]) cnt[c] = 0;
        pv[c] = code; pend[c] = 1;
      end
    end
    @(posedge clk); #5;
    check(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin act[c] = 255; pv[c] = 255; cnt[c] = 0; pend[c] = 0; neg[c] = 0; end
    repeat (3) @(posedge clk);
    #5;
    check("R11");
    rst_n = 1'b1;

    // R2 unity and rounding with mixed signs
    cyc(1, 1000, -1000, 0, 0, 0, "R2");
    cyc(1, 8388607, -8388608, 0, 0, 0, "R2");
    cyc(0, 5, 5, 0, 0, 0, "R1");
    // R5 immediate write, R4 right untouched
    cyc(0, 0, 0, 1, 0, 8'hF5, "R5");
    cyc(1, 123457, 123457, 0, 0, 0, "R4");
    cyc(1, -3, -77777, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 1, 8'hC1, "R4");
    cyc(1, 4000000, -4000000, 0, 0, 0, "R2");
    // R3 mute floor
    cyc(0, 0, 0, 1, 0, 8'h7F, "R3");
    cyc(1, 8000000, 100, 0, 0, 0, "R3");
    cyc(0, 0, 0, 1, 0, 8'h80, "R3");
    cyc(1, 8000000, 100, 0, 0, 0, "R3");
    cyc(1, -8388608, 100, 0, 0, 0, "R3");
    // R6 deferred until sign change
    zc = 1;
    cyc(1, 5000, 5000, 0, 0, 0, "R6");
    cyc(0, 0, 0, 1, 0, 8'hE0, "R6");
    cyc(1, 6000, 6000, 0, 0, 0, "R6");
    cyc(1, 7000, 7000, 0, 0, 0, "R6");
    cyc(1, -7000, 7000, 0, 0, 0, "R6");
    cyc(1, -9000, 7000, 0, 0, 0, "R6");
    // R6 zero sample commits
    cyc(0, 0, 0, 1, 1, 8'hFF, "R6");
    cyc(1, -9000, 7000, 0, 0, 0, "R6");
    cyc(1, -9000, 0, 0, 0, 0, "R6");
    cyc(1, -9000, 7000, 0, 0, 0, "R6");
    // R8 latest pending wins
    cyc(0, 0, 0, 1, 0, 8'h90, "R8");
    cyc(1, -9000, 7000, 1, 0, 8'hD0, "R8");
    cyc(1, -9100, 7000, 0, 0, 0, "R8");
    cyc(1, 9100, 7000, 0, 0, 0, "R8");
    // R9 write and committing sample in one cycle
    cyc(0, 0, 0, 1, 0, 8'hB0, "R9");
    cyc(1, -9100, 7000, 1, 0, 8'hF0, "R9");
    cyc(1, -9200, 7000, 0, 0, 0, "R9");
    cyc(1, 9200, 7000, 0, 0, 0, "R9");
    // R7 timeout, with a replacing write not restarting the count
    cyc(0, 0, 0, 1, 0, 8'hA0, "R7");
    cyc(1, 9300, 7000, 0, 0, 0, "R7");
    cyc(1, 9300, 7000, 1, 0, 8'hC8, "R7");
    for (int i = 0; i < 1024; i++) cyc(1, 9300, 7000, 0, 0, 0, "R7");
    // R9 write on the forcing sample
    cyc(0, 0, 0, 1, 1, 8'hE8, "R9");
    for (int i = 0; i < 1023; i++) cyc(1, 9300, 7000, 0, 0, 0, "R7");
    cyc(1, 9300, 7000, 1, 1, 8'hF8, "R9");
    cyc(1, 9300, 7000, 0, 0, 0, "R9");
    cyc(1, 9300, -7000, 0, 0, 0, "R9");
    // R10 pending code applied once zc_en drops
    cyc(0, 0, 0, 1, 0, 8'h88, "R10");
    cyc(1, 9300, -7000, 0, 0, 0, "R10");
    zc = 0;
    cyc(1, 9300, -7000, 0, 0, 0, "R10");
    cyc(1, 9300, -7000, 0, 0, 0, "R10");
    // R5 write with zc_en low discards pending, same cycle as a sample
    zc = 1;
    cyc(0, 0, 0, 1, 0, 8'hA8, "R5");
    zc = 0;
    cyc(1, 9300, -7000, 1, 0, 8'hEE, "R5");
    cyc(1, 9300, -7000, 0, 0, 0, "R5");
    cyc(0, 1, 1, 0, 0, 0, "R1");
    cyc(0, 1, 1, 0, 0, 0, "R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule